// File: doc/BRIEF.md
# Vector Carry-Less Multiply Unit

This unit multiplies vectors of 64-bit elements in GF(2), polynomial fashion with XOR in place of addition, and keeps the low 64 bits of each 128-bit product. The first operand of every element comes from source A. The second operand comes from the matching element of source B in vector mode, or from one 64-bit scalar shared by all elements in scalar mode.

A start pulse captures all operands, the old destination vector, the mask and the element window. The unit then steps through the window one element per clock cycle in ascending order. Each active element in the window gets its product. All other elements keep their old destination value. A one-cycle done pulse marks the end of the operation. In the same cycle a pulse tells the surrounding pipeline to clear its start-index register. The latency depends only on the window size, not on the mask.

Top module: `vclmul_unit`

## Requirements
- R1: A written element equals the low 64 bits of the carry-less product of its operands. The product starts at zero. For every bit j set in the second operand, the first operand shifted left by j is XORed in, and bits shifted past position 63 are lost.
- R2: With `scalar_mode_i`=0, element i uses element i of `src_b_i` as its second operand. With `scalar_mode_i`=1, every element uses `scalar_i`. Element i occupies bits [64*i+63 : 64*i] of every packed vector port.
- R3: Only indices from `vstart_i` up to the effective vl minus one are written. Every other element of `dst_o` equals the same element of `old_dst_i`.
- R4: With `mask_en_i`=1, an element in the window is written only when its bit `mask_i[i]` is 1 and otherwise keeps its old value. With `mask_en_i`=0, every element in the window is written, whatever `mask_i` holds.
- R5: If k indices lie in the window, `done_o` is high for exactly one cycle, starting k clock edges after the edge that samples `start_i`. For k=0 that is the cycle right after the start edge. Masked-off indices still take a cycle. `dst_o` holds the result from the done cycle until the next accepted start.
- R6: `vstart_clr_o` is high in exactly the cycles where `done_o` is high.
- R7: A start pulse that arrives while an operation is in progress is ignored. It changes neither the result, the latency, nor the number of done pulses.
- R8: A `vl_i` larger than NUM_ELEM is treated as NUM_ELEM.
- R9: After reset, `dst_o` is all zeros, and `done_o` and `vstart_clr_o` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Begin an operation; sampled only when idle |
| scalar_mode_i | input | 1 | 0: vector operand B, 1: broadcast scalar |
| src_a_i | input | NUM_ELEM*64 | First operand vector |
| src_b_i | input | NUM_ELEM*64 | Second operand vector (vector mode) |
| scalar_i | input | 64 | Second operand (scalar mode) |
| old_dst_i | input | NUM_ELEM*64 | Previous destination contents |
| mask_i | input | NUM_ELEM | Per-element activity bits |
| mask_en_i | input | 1 | Apply mask_i when 1 |
| vstart_i | input | $clog2(NUM_ELEM+1) | First element index to process |
| vl_i | input | $clog2(NUM_ELEM+1) | Vector length (end index, exclusive) |
| dst_o | output | NUM_ELEM*64 | Destination vector |
| done_o | output | 1 | One-cycle completion pulse |
| vstart_clr_o | output | 1 | Request to reset the start index |

## Verification
If the element counter runs wrong, `done_o` arrives on the wrong cycle, and the bench sees that at the first completion. Elements outside the window would also be overwritten, so `dst_o` differs from `old_dst_i` right at the done pulse. A bad latched mask or mode corrupts individual 64-bit lanes of `dst_o`, and the lane-by-lane comparison in that same cycle shows it. A fault in the XOR tree shows up first on single-bit and all-ones operands, where a dropped or kept overflow bit changes a known pattern.

// File: rtl/vclmul_pkg.sv
package vclmul_pkg;

  localparam int ELEM_W = 64;

  typedef logic [ELEM_W-1:0] elem_t;

  typedef enum logic [1:0] {
    CTL_IDLE = 2'd0,
    CTL_RUN  = 2'd1,
    CTL_FIN  = 2'd2
  } ctl_state_t;

  // One row of the partial-product array: operand shifted by the bit index,
  // gated by that bit of the multiplier. Upper bits fall off the field.
  function automatic elem_t pp_row(elem_t a, logic bbit, int unsigned sh);
    return bbit ? (a << sh) : '0;
  endfunction

  // Second operand selection for one element.
  function automatic elem_t pick_b(logic use_scalar, elem_t vec_b, elem_t scal);
    return use_scalar ? scal : vec_b;
  endfunction

endpackage

// File: rtl/vclmul_mult.sv
module vclmul_mult
  import vclmul_pkg::*;
(
  input  elem_t op_a_i,
  input  elem_t op_b_i,
  output elem_t prod_o
);

  elem_t acc [ELEM_W+1];

  assign acc[0] = '0;

  for (genvar g = 0; g < ELEM_W; g++) begin : g_row
    assign acc[g+1] = acc[g] ^ pp_row(op_a_i, op_b_i[g], g);
  end

  assign prod_o = acc[ELEM_W];

endmodule

// File: rtl/vclmul_ctrl.sv
module vclmul_ctrl
  import vclmul_pkg::*;
#(
  parameter int NUM_ELEM = 4,
  parameter int CW       = $clog2(NUM_ELEM + 1),
  parameter int IW       = (NUM_ELEM > 1) ? $clog2(NUM_ELEM) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start_i,
  input  logic [CW-1:0] vstart_i,
  input  logic [CW-1:0] vl_i,
  output logic          accept_o,
  output logic          step_o,
  output logic [IW-1:0] idx_o,
  output logic          done_o
);

  localparam logic [CW-1:0] NUM_C = CW'(NUM_ELEM);
  localparam logic [CW-1:0] ONE_C = CW'(1);

  ctl_state_t    state_q;
  logic [CW-1:0] idx_q;
  logic [CW-1:0] last_q;
  logic [CW-1:0] vl_eff;
  logic          empty_win;
  logic          at_last;

  assign vl_eff    = (vl_i > NUM_C) ? NUM_C : vl_i;
  assign empty_win = (vstart_i >= vl_eff);
  assign accept_o  = (state_q == CTL_IDLE) && start_i;
  assign at_last   = (idx_q == last_q);
  assign step_o    = (state_q == CTL_RUN);
  assign done_o    = (state_q == CTL_FIN);
  assign idx_o     = idx_q[IW-1:0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= CTL_IDLE;
      idx_q   <= '0;
      last_q  <= '0;
    end else begin
      unique case (state_q)
        CTL_IDLE: begin
          if (start_i) begin
            idx_q   <= vstart_i;
            last_q  <= vl_eff - ONE_C;
            state_q <= empty_win ? CTL_FIN : CTL_RUN;
          end
        end
        CTL_RUN: begin
          if (at_last) state_q <= CTL_FIN;
          else         idx_q   <= idx_q + ONE_C;
        end
        CTL_FIN:  state_q <= CTL_IDLE;
        default:  state_q <= CTL_IDLE;
      endcase
    end
  end

  // R5: completion is a single-cycle pulse
  a_r5_done_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);

  // R5: an empty window completes in the cycle after start
  a_r5_empty_fast: assert property (@(posedge clk) disable iff (!rst_n)
    (accept_o && empty_win) |=> done_o);

  // R3: the active index never leaves the window or the vector
  a_r3_index_in_window: assert property (@(posedge clk) disable iff (!rst_n)
    step_o |-> (idx_q <= last_q) && (last_q < NUM_C));

  // R7: a running operation keeps stepping, no restart
  a_r7_run_continues: assert property (@(posedge clk) disable iff (!rst_n)
    (step_o && !at_last) |=> (step_o && idx_q == $past(idx_q) + ONE_C));

endmodule

// File: rtl/vclmul_dst.sv
module vclmul_dst
  import vclmul_pkg::*;
#(
  parameter int NUM_ELEM = 4,
  parameter int IW       = (NUM_ELEM > 1) ? $clog2(NUM_ELEM) : 1
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       load_i,
  input  logic                       scalar_mode_i,
  input  logic [NUM_ELEM*ELEM_W-1:0] src_a_i,
  input  logic [NUM_ELEM*ELEM_W-1:0] src_b_i,
  input  elem_t                      scalar_i,
  input  logic [NUM_ELEM*ELEM_W-1:0] old_dst_i,
  input  logic [NUM_ELEM-1:0]        mask_i,
  input  logic                       mask_en_i,
  input  logic                       step_i,
  input  logic [IW-1:0]              idx_i,
  input  elem_t                      prod_i,
  output elem_t                      op_a_o,
  output elem_t                      op_b_o,
  output logic [NUM_ELEM*ELEM_W-1:0] dst_o
);

  logic [NUM_ELEM-1:0][ELEM_W-1:0] a_q;
  logic [NUM_ELEM-1:0][ELEM_W-1:0] b_q;
  logic [NUM_ELEM-1:0][ELEM_W-1:0] dst_q;
  elem_t                           scal_q;
  logic                            mode_q;
  logic [NUM_ELEM-1:0]             act_q;
  logic                            wr_en;
  logic                            skip_ev;

  assign op_a_o  = a_q[idx_i];
  assign op_b_o  = pick_b(mode_q, b_q[idx_i], scal_q);
  assign wr_en   = step_i && act_q[idx_i];
  assign skip_ev = step_i && !act_q[idx_i];
  assign dst_o   = dst_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      a_q    <= '0;
      b_q    <= '0;
      scal_q <= '0;
      mode_q <= 1'b0;
      act_q  <= '0;
    end else if (load_i) begin
      a_q    <= src_a_i;
      b_q    <= src_b_i;
      scal_q <= scalar_i;
      mode_q <= scalar_mode_i;
      act_q  <= mask_en_i ? mask_i : '1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      dst_q         <= '0;
    else if (load_i) dst_q         <= old_dst_i;
    else if (wr_en)  dst_q[idx_i]  <= prod_i;
  end

  // R4: a masked-off element leaves the destination untouched
  a_r4_inactive_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (skip_ev && !load_i) |=> $stable(dst_q));

  // R3: outside loading and stepping the destination does not move
  a_r3_quiet_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!step_i && !load_i) |=> $stable(dst_q));

endmodule

// File: rtl/vclmul_unit.sv
module vclmul_unit
  import vclmul_pkg::*;
#(
  parameter int NUM_ELEM = 4,
  parameter int CW       = $clog2(NUM_ELEM + 1)
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       start_i,
  input  logic                       scalar_mode_i,
  input  logic [NUM_ELEM*ELEM_W-1:0] src_a_i,
  input  logic [NUM_ELEM*ELEM_W-1:0] src_b_i,
  input  logic [ELEM_W-1:0]          scalar_i,
  input  logic [NUM_ELEM*ELEM_W-1:0] old_dst_i,
  input  logic [NUM_ELEM-1:0]        mask_i,
  input  logic                       mask_en_i,
  input  logic [CW-1:0]              vstart_i,
  input  logic [CW-1:0]              vl_i,
  output logic [NUM_ELEM*ELEM_W-1:0] dst_o,
  output logic                       done_o,
  output logic                       vstart_clr_o
);

  localparam int IW = (NUM_ELEM > 1) ? $clog2(NUM_ELEM) : 1;

  logic          accept_ev;
  logic          step_ev;
  logic [IW-1:0] cur_idx;
  elem_t         mul_a;
  elem_t         mul_b;
  elem_t         mul_p;

  vclmul_ctrl #(.NUM_ELEM(NUM_ELEM), .CW(CW), .IW(IW)) ctrl_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .start_i  (start_i),
    .vstart_i (vstart_i),
    .vl_i     (vl_i),
    .accept_o (accept_ev),
    .step_o   (step_ev),
    .idx_o    (cur_idx),
    .done_o   (done_o)
  );

  vclmul_dst #(.NUM_ELEM(NUM_ELEM), .IW(IW)) dst_i (
    .clk           (clk),
    .rst_n         (rst_n),
    .load_i        (accept_ev),
    .scalar_mode_i (scalar_mode_i),
    .src_a_i       (src_a_i),
    .src_b_i       (src_b_i),
    .scalar_i      (scalar_i),
    .old_dst_i     (old_dst_i),
    .mask_i        (mask_i),
    .mask_en_i     (mask_en_i),
    .step_i        (step_ev),
    .idx_i         (cur_idx),
    .prod_i        (mul_p),
    .op_a_o        (mul_a),
    .op_b_o        (mul_b),
    .dst_o         (dst_o)
  );

  vclmul_mult mult_i (
    .op_a_i (mul_a),
    .op_b_i (mul_b),
    .prod_o (mul_p)
  );

  assign vstart_clr_o = done_o;

  // R1: a zero first operand gives a zero product
  a_r1_zero_operand: assert property (@(posedge clk) disable iff (!rst_n)
    (step_ev && mul_a == '0) |-> (mul_p == '0));

  // R1: multiplying by the polynomial 1 returns the first operand
  a_r1_unit_operand: assert property (@(posedge clk) disable iff (!rst_n)
    (step_ev && mul_b == elem_t'(1)) |-> (mul_p == mul_a));

  // R7: no accept while a result is pending
  a_r7_no_accept_busy: assert property (@(posedge clk) disable iff (!rst_n)
    step_ev |-> !accept_ev);

endmodule

// File: tb/vclmul_unit_tb_top.sv
module vclmul_unit_tb_top;

  localparam int N  = 4;
  localparam int EW = 64;
  localparam int CW = $clog2(N + 1);
  localparam int VW = N * EW;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          start_i = 1'b0;
  logic          scalar_mode_i = 1'b0;
  logic [VW-1:0] src_a_i = '0;
  logic [VW-1:0] src_b_i = '0;
  logic [EW-1:0] scalar_i = '0;
  logic [VW-1:0] old_dst_i = '0;
  logic [N-1:0]  mask_i = '0;
  logic          mask_en_i = 1'b0;
  logic [CW-1:0] vstart_i = '0;
  logic [CW-1:0] vl_i = '0;
  logic [VW-1:0] dst_o;
  logic          done_o;
  logic          vstart_clr_o;

  always #5 clk = ~clk;

  vclmul_unit #(.NUM_ELEM(N)) dut_i (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .scalar_mode_i(scalar_mode_i),
    .src_a_i(src_a_i), .src_b_i(src_b_i), .scalar_i(scalar_i),
    .old_dst_i(old_dst_i), .mask_i(mask_i), .mask_en_i(mask_en_i),
    .vstart_i(vstart_i), .vl_i(vl_i), .dst_o(dst_o), .done_o(done_o),
    .vstart_clr_o(vstart_clr_o)
  );

  int checks = 0;
  int fails  = 0;
  int cyc    = 0;
  int done_cnt = 0;
  bit finished = 1'b0;

  logic [VW-1:0] exp_q [$];
  int            due_q [$];
  string         tag_q [$];

  always @(posedge clk) cyc <= cyc + 1;

  task automatic check(input bit ok, input string req, input string act, input string exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%s expected=%s", req, act, exp);
    end
  endtask

  // bit-serial reference: walk the multiplier from LSB, shifting the multiplicand
  function automatic logic [EW-1:0] ref_clmul(logic [EW-1:0] a, logic [EW-1:0] b);
    logic [EW-1:0] r = '0;
    for (int j = 0; j < EW; j++) begin
      if (b[0]) r = r ^ a;
      a = a << 1;
      b = b >> 1;
    end
    return r;
  endfunction

  function automatic logic [EW-1:0] rnd64();
    return {$urandom(), $urandom()};
  endfunction

  // monitor: pops expected items as completions appear
  always @(negedge clk) begin
    if (rst_n && !finished) begin
      if (done_o) begin
        done_cnt++;
        if (exp_q.size() == 0) begin
          check(1'b0, "R7", "done", "no pending operation");
        end else begin
          logic [VW-1:0] e;
          int d;
          string t;
          e = exp_q.pop_front();
          d = due_q.pop_front();
          t = tag_q.pop_front();
          check(dst_o === e, t, $sformatf("%h", dst_o), $sformatf("%h", e));
          check(cyc == d, {"R5 latency ", t}, $sformatf("%0d", cyc), $sformatf("%0d", d));
          check(vstart_clr_o === 1'b1, "R6", $sformatf("%b", vstart_clr_o), "1");
        end
      end else if (vstart_clr_o !== 1'b0) begin
        check(1'b0, "R6", $sformatf("%b", vstart_clr_o), "0");
      end
    end
  end

  task automatic run_op(input bit mode, input logic [VW-1:0] a, input logic [VW-1:0] b,
                        input logic [EW-1:0] scal, input logic [VW-1:0] old,
                        input logic [N-1:0] msk, input bit men,
                        input int vs, input int vl, input bit inject, input string tag);
    logic [VW-1:0] e;
    int vle, k, prev;
    @(negedge clk);
    scalar_mode_i = mode; src_a_i = a; src_b_i = b; scalar_i = scal;
    old_dst_i = old; mask_i = msk; mask_en_i = men;
    vstart_i = CW'(vs); vl_i = CW'(vl); start_i = 1'b1;
    vle = (vl > N) ? N : vl;
    e = old;
    k = 0;
    for (int i = 0; i < N; i++) begin
      if (i >= vs && i < vle) begin
        k++;
        if (!men || msk[i])
          e[i*EW +: EW] = ref_clmul(a[i*EW +: EW], mode ? scal : b[i*EW +: EW]);
      end
    end
    exp_q.push_back(e);
    due_q.push_back(cyc + 1 + k);
    tag_q.push_back(tag);
    prev = done_cnt;
    @(negedge clk);
    start_i = 1'b0;
    // disturb every operand, then pulse start during the run
    src_a_i = ~a; src_b_i = ~b; scalar_i = ~scal; old_dst_i = ~old; mask_i = ~msk;
    vstart_i = '0; vl_i = CW'(N);
    if (inject) begin
      start_i = 1'b1;
      @(negedge clk);
      start_i = 1'b0;
    end
    while (done_cnt == prev) @(negedge clk);
    repeat (3) @(negedge clk);
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      fails++;
      checks++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin : driver
    logic [VW-1:0] ra, rb, ro;
    logic [EW-1:0] ones;
    ones = '1;
    repeat (3) @(negedge clk);
    // R9: reset values
    check(dst_o === '0, "R9 dst", $sformatf("%h", dst_o), "0");
    check(done_o === 1'b0, "R9 done", $sformatf("%b", done_o), "0");
    check(vstart_clr_o === 1'b0, "R9 clr", $sformatf("%b", vstart_clr_o), "0");
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    check(dst_o === '0 && done_o === 1'b0, "R9 idle", $sformatf("%b", done_o), "0");

    for (int t = 0; t < 4; t++) begin
      ra = {rnd64(), rnd64(), rnd64(), rnd64()};
      rb = {rnd64(), rnd64(), rnd64(), rnd64()};
      ro = {rnd64(), rnd64(), rnd64(), rnd64()};
      run_op(1'b0, ra, rb, '0, ro, '0, 1'b0, 0, 4, 1'b0, "R1 R2 vector random");
    end
    ro = {rnd64(), rnd64(), rnd64(), rnd64()};
    run_op(1'b0, {N{ones}}, {N{ones}}, '0, ro, '0, 1'b0, 0, 4, 1'b0, "R1 all ones");
    run_op(1'b0, '0, {N{ones}}, '0, ro, '0, 1'b0, 0, 4, 1'b0, "R1 zeros");
    run_op(1'b0, {64'h8000_0000_0000_0000, 64'h20, 64'h1, 64'h8000_0000_0000_0001},
           {64'h2, 64'h80, 64'h8000_0000_0000_0000, 64'h8000_0000_0000_0000},
           '0, ro, '0, 1'b0, 0, 4, 1'b0, "R1 single bits overflow");
    ra = {rnd64(), rnd64(), rnd64(), rnd64()};
    run_op(1'b1, ra, {rnd64(), rnd64(), rnd64(), rnd64()}, rnd64(), ro, '0, 1'b0, 0, 4, 1'b0,
           "R2 scalar broadcast");
    run_op(1'b1, ra, '0, 64'h1, ro, '0, 1'b0, 0, 4, 1'b0, "R2 scalar one");
    run_op(1'b0, ra, {rnd64(), rnd64(), rnd64(), rnd64()}, '0, ro, 4'b0101, 1'b1, 0, 4, 1'b0,
           "R4 masked");
    run_op(1'b0, ra, {rnd64(), rnd64(), rnd64(), rnd64()}, '0, ro, 4'b0000, 1'b0, 0, 4, 1'b0,
           "R4 mask disabled");
    run_op(1'b0, ra, {rnd64(), rnd64(), rnd64(), rnd64()}, '0, ro, 4'b0000, 1'b1, 0, 4, 1'b0,
           "R4 all masked");
    run_op(1'b0, ra, {rnd64(), rnd64(), rnd64(), rnd64()}, '0, ro, '0, 1'b0, 1, 3, 1'b0,
           "R3 partial window");
    run_op(1'b0, ra, {rnd64(), rnd64(), rnd64(), rnd64()}, '0, ro, '0, 1'b0, 3, 2, 1'b0,
           "R3 R5 empty window");
    run_op(1'b0, ra, {rnd64(), rnd64(), rnd64(), rnd64()}, '0, ro, '0, 1'b0, 4, 4, 1'b0,
           "R3 R5 start at end");
    run_op(1'b0, ra, {rnd64(), rnd64(), rnd64(), rnd64()}, '0, ro, '0, 1'b0, 2, 7, 1'b0,
           "R8 vl clamp");
    run_op(1'b1, ra, '0, rnd64(), ro, 4'b1110, 1'b1, 1, 4, 1'b1, "R7 start while busy");
    run_op(1'b0, ra, {rnd64(), rnd64(), rnd64(), rnd64()}, '0, ro, '0, 1'b0, 3, 4, 1'b1,
           "R7 start during single element");
    repeat (5) @(negedge clk);
    check(exp_q.size() == 0, "R7 pending", $sformatf("%0d", exp_q.size()), "0");
    check(dst_o === dst_o && done_o === 1'b0, "R5 quiet after run", $sformatf("%b", done_o), "0");
    if (!finished) begin
      finished = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

endmodule